// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device side of a four-wire serial flash interface. It sits behind the chip-select, serial clock and serial data pins, and it runs entirely on the system clock. The pin inputs are oversampled through two-stage synchronizers. Incoming bits are taken on each rising serial-clock edge, most significant bit first, and grouped into 8-bit bus cycles. The first bus cycle of a selection is an opcode. Some opcodes are followed by a 24-bit address and by data bytes.

Decoded commands act on a small byte array with a parameterized size. Reads stream array contents, the status byte or identification bytes for as long as the serial clock keeps running. Program and erase operations change the array only when a write-enable latch was set beforehand, and they take effect only when chip-select rises at a clean bus-cycle boundary. Erase runs as a sweep that writes 0xFF one byte per system clock, and a busy flag is set for the length of the sweep.

The block also holds three other pieces of state: the write-enable latch, a sequential-programming mode flag and a one-shot arming flag for status writes. The serial output is registered on falling serial-clock edges. It comes with an enable that is low outside output phases, so that a pad buffer can tri-state the pin.

Top module: `sflash_front`

## Requirements
- R1: After reset, the status byte reads 0x00 and `so_oe` is 0.
- R2: Input bits are taken MSB first on rising `sck` edges while `cs_n` is low. Output bits change only on falling `sck` edges. `so_oe` is 1 only during the data phase of opcode 0x03 (read), 0x05 (status read) or 0x90/0xAB (identification).
- R3: Opcode 0x03 followed by three address bytes (high byte first) streams array bytes starting at that address and incrementing by one per byte. Address bits at or above ADDR_W are ignored.
- R4: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it. Program (0x02), sequential program (0xAF) and erase (0x20, 0x52, 0x60) are ignored while the latch is clear.
- R5: Opcode 0x02 with three address bytes and one data byte writes that byte to the array and clears the write-enable latch.
- R6: A command executes only if `cs_n` rises at a bus-cycle boundary after its final byte. A rise in the middle of a bus cycle, or before the final byte, leaves every state unchanged.
- R7: Opcode 0x01 with one data byte stores data bits 7 and 5..2 into the same status bit positions. It does so only when the previous command was 0x50. In every other case the status byte is unchanged.
- R8: Opcode 0xAF with an address and a data byte writes that byte and sets the sequential flag (status bit 6). Each further 0xAF with one data byte writes to the next address. Opcode 0x04 clears the flag.
- R9: Opcodes 0x90 and 0xAB take three bytes. Bit 0 of the last byte selects the first output: 0 gives the maker code (default 0xBF) and 1 gives the device code 0x48. Output then alternates between the two codes for each further byte.
- R10: Opcode 0x20 fills the aligned 2^SECTOR_W-byte region containing the address with 0xFF. Opcode 0x52 does the same for the 2^BLOCK_W-byte region, and opcode 0x60 for the whole array. Status bit 0 is 1 while the fill runs, the write-enable latch clears when the fill starts, and every opcode other than 0x05 is ignored until the fill ends.
- R11: Opcode 0x05 streams the status byte repeatedly until `cs_n` rises. The bit layout is: bit 0 busy, bit 1 write-enable latch, bits 5..2 and 7 stored, bit 6 sequential flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data into the device |
| so | output | 1 | Serial data out of the device, registered |
| so_oe | output | 1 | Output enable for `so`; 0 means high-impedance |

## Verification
The bench attacks selections that end early: after five opcode bits, after one full opcode plus three extra bits, and after the address of a program with no data byte. A front-end that executes on any chip-select rise would set the write-enable latch, or write the array, in these cases. It pairs a status write with a preceding enable only when the two commands are adjacent. A design that kept the arming flag across an intervening status read would change the stored bits.

Sector and block fills are checked on both sides of their aligned boundaries, together with a byte outside the block. An off-by-one in the sweep range would show as a stray 0xFF or a surviving byte. A write-enable issued during a running fill must not stick. Streaming reads cross byte boundaries for data, status and identification alike. A wrong output bit index, or a late update of the next byte, would corrupt the first bit of every byte after the first.

// File: rtl/sflash_pkg.sv
`timescale 1ns/1ps
package sflash_pkg;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_SECT   = 8'h20;
  localparam logic [7:0] OP_BLK    = 8'h52;
  localparam logic [7:0] OP_CHIP   = 8'h60;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SEQ    = 8'hAF;
  localparam logic [7:0] OP_STAT   = 8'h05;
  localparam logic [7:0] OP_ARM    = 8'h50;
  localparam logic [7:0] OP_WSTAT  = 8'h01;
  localparam logic [7:0] OP_WEN    = 8'h06;
  localparam logic [7:0] OP_WDIS   = 8'h04;
  localparam logic [7:0] OP_IDA    = 8'h90;
  localparam logic [7:0] OP_IDB    = 8'hAB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_STREAM, ST_END, ST_DISC
  } phase_e;

  typedef enum logic [3:0] {
    K_NONE, K_READ, K_IDENT, K_PROG, K_SEQ1, K_SEQN,
    K_SECT, K_BLK, K_CHIP, K_WEN, K_WDIS, K_ARM, K_WSTAT
  } kind_e;

  typedef enum logic [1:0] {
    SM_MEM, SM_STAT, SM_ID
  } smode_e;

endpackage

// File: rtl/sflash_rx.sv
`timescale 1ns/1ps
module sflash_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       cs_act,
  output logic       cs_end,
  output logic       sck_fall,
  output logic [2:0] bit_idx,
  output logic       byte_vld,
  output logic [7:0] byte_data
);

  logic sck_m, sck_q, sck_d;
  logic cs_m, cs_q, cs_d;
  logic si_m, si_q;
  logic [6:0] sh;
  logic sck_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_m <= 1'b0; sck_q <= 1'b0; sck_d <= 1'b0;
      cs_m  <= 1'b1; cs_q  <= 1'b1; cs_d  <= 1'b1;
      si_m  <= 1'b0; si_q  <= 1'b0;
    end else begin
      sck_m <= sck;  sck_q <= sck_m; sck_d <= sck_q;
      cs_m  <= cs_n; cs_q  <= cs_m;  cs_d  <= cs_q;
      si_m  <= si;   si_q  <= si_m;
    end
  end

  assign cs_act   = ~cs_q;
  assign cs_end   = cs_q & ~cs_d;
  assign sck_rise = sck_q & ~sck_d & ~cs_q;
  assign sck_fall = ~sck_q & sck_d & ~cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      bit_idx   <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (cs_q) begin
        bit_idx <= '0;
      end else if (sck_rise) begin
        sh      <= {sh[5:0], si_q};
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {sh, si_q};
        end
      end
    end
  end

endmodule

// File: rtl/sflash_ctrl.sv
`timescale 1ns/1ps
module sflash_ctrl
  import sflash_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SECTOR_W = 8,
  parameter int BLOCK_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              cs_end,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic [2:0]        bit_idx,
  input  logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  output smode_e            smode,
  output logic              out_en,
  output logic              id_sel,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              er_start,
  output logic [ADDR_W-1:0] er_base,
  output logic [ADDR_W-1:0] er_mask,
  output logic [7:0]        status
);

  localparam logic [ADDR_W-1:0] SEC_MASK = {{(ADDR_W-SECTOR_W){1'b0}}, {SECTOR_W{1'b1}}};
  localparam logic [ADDR_W-1:0] BLK_MASK = {{(ADDR_W-BLOCK_W){1'b0}}, {BLOCK_W{1'b1}}};
  localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};

  phase_e            phase;
  kind_e             kind;
  logic [1:0]        acnt;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] seq_addr;
  logic [7:0]        dbyte;
  logic              wel, seq, arm;
  logic [4:0]        keep;
  logic              allowed;

  assign status = {keep[4], seq, keep[3:0], wel, busy};
  assign out_en = (phase == ST_STREAM);

  // In sequential mode only continuation, disable and status read act.
  assign allowed = ~seq | (byte_data == OP_SEQ) | (byte_data == OP_WDIS) |
                   (byte_data == OP_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= ST_IDLE;
      kind     <= K_NONE;
      acnt     <= '0;
      addr_q   <= '0;
      seq_addr <= '0;
      dbyte    <= '0;
      wel      <= 1'b0;
      seq      <= 1'b0;
      arm      <= 1'b0;
      keep     <= '0;
      rd_addr  <= '0;
      smode    <= SM_STAT;
      id_sel   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      er_start <= 1'b0;
      er_base  <= '0;
      er_mask  <= '0;
    end else begin
      wr_en    <= 1'b0;
      er_start <= 1'b0;
      if (!cs_act) begin
        phase <= ST_IDLE;
        if (cs_end && phase == ST_END && bit_idx == 3'd0) begin
          case (kind)
            K_PROG: begin
              wr_en <= 1'b1; wr_addr <= addr_q; wr_data <= dbyte; wel <= 1'b0;
            end
            K_SEQ1: begin
              wr_en <= 1'b1; wr_addr <= addr_q; wr_data <= dbyte;
              seq <= 1'b1; seq_addr <= addr_q + ONE;
            end
            K_SEQN: begin
              wr_en <= 1'b1; wr_addr <= seq_addr; wr_data <= dbyte;
              seq_addr <= seq_addr + ONE;
            end
            K_SECT: begin
              er_start <= 1'b1; er_mask <= SEC_MASK; er_base <= addr_q & ~SEC_MASK; wel <= 1'b0;
            end
            K_BLK: begin
              er_start <= 1'b1; er_mask <= BLK_MASK; er_base <= addr_q & ~BLK_MASK; wel <= 1'b0;
            end
            K_CHIP: begin
              er_start <= 1'b1; er_mask <= '1; er_base <= '0; wel <= 1'b0;
            end
            K_WEN:   wel <= 1'b1;
            K_WDIS:  begin wel <= 1'b0; seq <= 1'b0; end
            K_ARM:   arm <= 1'b1;
            K_WSTAT: begin keep <= {dbyte[7], dbyte[5:2]}; wel <= 1'b0; end
            default: ;
          endcase
        end
      end else if (byte_vld) begin
        case (phase)
          ST_IDLE: begin
            arm  <= 1'b0;
            acnt <= '0;
            if ((busy && byte_data != OP_STAT) || !allowed) begin
              phase <= ST_DISC;
            end else begin
              case (byte_data)
                OP_READ: begin kind <= K_READ; smode <= SM_MEM; phase <= ST_ADDR; end
                OP_IDA, OP_IDB: begin kind <= K_IDENT; smode <= SM_ID; phase <= ST_ADDR; end
                OP_STAT: begin smode <= SM_STAT; phase <= ST_STREAM; end
                OP_PROG: begin kind <= K_PROG; phase <= wel ? ST_ADDR : ST_DISC; end
                OP_SEQ: begin
                  if (seq) begin kind <= K_SEQN; phase <= ST_DATA; end
                  else begin kind <= K_SEQ1; phase <= wel ? ST_ADDR : ST_DISC; end
                end
                OP_SECT: begin kind <= K_SECT; phase <= wel ? ST_ADDR : ST_DISC; end
                OP_BLK:  begin kind <= K_BLK;  phase <= wel ? ST_ADDR : ST_DISC; end
                OP_CHIP: begin kind <= K_CHIP; phase <= wel ? ST_END  : ST_DISC; end
                OP_WEN:  begin kind <= K_WEN;  phase <= ST_END; end
                OP_WDIS: begin kind <= K_WDIS; phase <= ST_END; end
                OP_ARM:  begin kind <= K_ARM;  phase <= ST_END; end
                OP_WSTAT: begin kind <= K_WSTAT; phase <= arm ? ST_DATA : ST_DISC; end
                default: phase <= ST_DISC;
              endcase
            end
          end
          ST_ADDR: begin
            addr_q <= ADDR_W'({addr_q, byte_data});
            acnt   <= acnt + 2'd1;
            if (acnt == 2'd2) begin
              case (kind)
                K_READ:  begin rd_addr <= ADDR_W'({addr_q, byte_data}); phase <= ST_STREAM; end
                K_IDENT: begin id_sel <= byte_data[0]; phase <= ST_STREAM; end
                K_PROG, K_SEQ1: phase <= ST_DATA;
                default: phase <= ST_END;
              endcase
            end
          end
          ST_DATA: begin
            dbyte <= byte_data;
            phase <= ST_END;
          end
          ST_STREAM: begin
            if (smode == SM_MEM) rd_addr <= rd_addr + ONE;
            id_sel <= ~id_sel;
          end
          ST_END:  phase <= ST_DISC;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sflash_array.sv
`timescale 1ns/1ps
module sflash_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              er_start,
  input  logic [ADDR_W-1:0] er_base,
  input  logic [ADDR_W-1:0] er_mask,
  output logic              busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] idx, base, mask;
  logic              we;
  logic [ADDR_W-1:0] wa;
  logic [7:0]        wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      base <= '0;
      mask <= '0;
    end else if (er_start) begin
      busy <= 1'b1;
      idx  <= '0;
      base <= er_base;
      mask <= er_mask;
    end else if (busy) begin
      if (idx == mask) busy <= 1'b0;
      idx <= idx + ONE;
    end
  end

  assign we = busy | wr_en;
  assign wa = busy ? (base | idx) : wr_addr;
  assign wd = busy ? 8'hFF : wr_data;

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/sflash_tx.sv
`timescale 1ns/1ps
module sflash_tx
  import sflash_pkg::*;
#(
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'h48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_act,
  input  logic       sck_fall,
  input  logic       out_en,
  input  logic [2:0] bit_idx,
  input  smode_e     smode,
  input  logic [7:0] rd_data,
  input  logic [7:0] status,
  input  logic       id_sel,
  output logic       so,
  output logic       so_oe
);

  logic [7:0] tx_byte;

  always_comb begin
    case (smode)
      SM_MEM:  tx_byte = rd_data;
      SM_STAT: tx_byte = status;
      default: tx_byte = id_sel ? DEV_ID : MFR_ID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      if (!cs_act || !out_en) so_oe <= 1'b0;
      else if (sck_fall)      so_oe <= 1'b1;
      if (sck_fall && out_en && cs_act) so <= tx_byte[3'd7 - bit_idx];
    end
  end

endmodule

// File: rtl/sflash_front.sv
`timescale 1ns/1ps
module sflash_front
  import sflash_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter int         SECTOR_W = 8,
  parameter int         BLOCK_W  = 9,
  parameter logic [7:0] MFR_ID   = 8'hBF,
  parameter logic [7:0] DEV_ID   = 8'h48
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_oe
);

  logic              cs_act, cs_end, sck_fall, byte_vld;
  logic [2:0]        bit_idx;
  logic [7:0]        byte_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr, er_base, er_mask;
  logic [7:0]        rd_data, wr_data, status;
  logic              wr_en, er_start, busy, out_en, id_sel;
  smode_e            smode;

  sflash_rx u_rx (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
    .cs_act(cs_act), .cs_end(cs_end), .sck_fall(sck_fall),
    .bit_idx(bit_idx), .byte_vld(byte_vld), .byte_data(byte_data)
  );

  sflash_ctrl #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_act(cs_act), .cs_end(cs_end),
    .byte_vld(byte_vld), .byte_data(byte_data), .bit_idx(bit_idx), .busy(busy),
    .rd_addr(rd_addr), .smode(smode), .out_en(out_en), .id_sel(id_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .er_start(er_start), .er_base(er_base), .er_mask(er_mask), .status(status)
  );

  sflash_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .er_start(er_start), .er_base(er_base), .er_mask(er_mask), .busy(busy)
  );

  sflash_tx #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_tx (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_fall(sck_fall), .out_en(out_en),
    .bit_idx(bit_idx), .smode(smode), .rd_data(rd_data), .status(status),
    .id_sel(id_sel), .so(so), .so_oe(so_oe)
  );

endmodule

// File: rtl/sflash_front_chk.sv
`timescale 1ns/1ps
module sflash_front_chk (
  input logic clk,
  input logic rst,
  input logic cs_act,
  input logic sck_fall,
  input logic so,
  input logic so_oe,
  input logic wr_en,
  input logic er_start,
  input logic busy,
  input logic wel,
  input logic seq
);

  assert_oe_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !so_oe);

  assert_so_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (so_oe && !sck_fall) |=> $stable(so));

  assert_write_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(wel));

  assert_erase_needs_wel_R10: assert property (@(posedge clk) disable iff (rst)
    er_start |-> ($past(wel) && !busy));

  assert_erase_drops_wel_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wel);

  assert_no_write_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !wr_en);

  assert_seq_has_wel_R8: assert property (@(posedge clk) disable iff (rst)
    seq |-> wel);

endmodule

bind sflash_front sflash_front_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .sck_fall(sck_fall),
  .so(so), .so_oe(so_oe), .wr_en(wr_en), .er_start(er_start),
  .busy(busy), .wel(status[1]), .seq(status[6])
);

// File: tb/sflash_front_bench.sv
`timescale 1ns/1ps
module sflash_front_bench;

  localparam int HALF = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, sck, cs_n, si;
  logic so, so_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       got_ev;
  logic [7:0] got_b;

  sflash_front u_sflash_front (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_b(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // cap=1: byte is an output byte, so_oe must be high and the byte goes to the monitor.
  // cap=0: input byte, so_oe must stay low (R2).
  task automatic xbyte(input logic [7:0] tx, input bit cap);
    logic [7:0] rx;
    bit oe_ok;
    oe_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      wait_clk(HALF);
      rx[i] = so;
      if (so_oe !== cap) oe_ok = 1'b0;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    chk(oe_ok, "R2 so_oe phase", {7'd0, ~cap}, {7'd0, cap});
    if (cap) begin
      got_b = rx;
      -> got_ev;
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic desel();
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); xbyte(op, 1'b0); desel();
  endtask

  task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a, input bit has_d, input logic [7:0] d);
    sel();
    xbyte(op, 1'b0);
    xbyte(a[23:16], 1'b0); xbyte(a[15:8], 1'b0); xbyte(a[7:0], 1'b0);
    if (has_d) xbyte(d, 1'b0);
    desel();
  endtask

  task automatic cmd_data(input logic [7:0] op, input logic [7:0] d);
    sel(); xbyte(op, 1'b0); xbyte(d, 1'b0); desel();
  endtask

  task automatic stream(input logic [7:0] op, input bit with_addr, input logic [23:0] a, input int n);
    sel();
    xbyte(op, 1'b0);
    if (with_addr) begin
      xbyte(a[23:16], 1'b0); xbyte(a[15:8], 1'b0); xbyte(a[7:0], 1'b0);
    end
    for (int k = 0; k < n; k++) xbyte(8'h00, 1'b1);
    desel();
  endtask

  task automatic stat_is(input logic [7:0] v, input string tag);
    expect_b(v, tag); expect_b(v, tag);
    stream(8'h05, 1'b0, 24'd0, 2);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected output byte", got_b, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got_b === e, t, got_b, e);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    rst = 1'b1; sck = 1'b0; cs_n = 1'b1; si = 1'b0;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(4);
    chk(so_oe === 1'b0, "R1 so_oe after reset", {7'd0, so_oe}, 8'h00);
    stat_is(8'h00, "R1 R11 status after reset");

    // Chip erase, busy visible while the fill runs
    cmd1(8'h06);
    stat_is(8'h02, "R4 WREN sets bit1");
    cmd1(8'h60);
    stat_is(8'h01, "R10 busy set, WEL cleared");
    wait_clk(1200);
    stat_is(8'h00, "R10 busy cleared after fill");
    expect_b(8'hFF, "R10 chip fill"); expect_b(8'hFF, "R10 chip fill");
    stream(8'h03, 1'b1, 24'h0003FE, 2);

    // Program without latch is ignored
    cmd_addr(8'h02, 24'h000020, 1'b1, 8'h12);
    expect_b(8'hFF, "R4 program ignored without WREN");
    stream(8'h03, 1'b1, 24'h000020, 1);

    // Latch set then cleared by disable
    cmd1(8'h06); cmd1(8'h04);
    stat_is(8'h00, "R4 WRDI clears bit1");

    // Proper program
    cmd1(8'h06);
    cmd_addr(8'h02, 24'h000020, 1'b1, 8'h12);
    stat_is(8'h00, "R5 WEL cleared after program");
    expect_b(8'hFF, "R3 stream"); expect_b(8'h12, "R5 programmed byte"); expect_b(8'hFF, "R3 stream");
    stream(8'h03, 1'b1, 24'h00001F, 3);
    expect_b(8'h12, "R3 upper address bits ignored");
    stream(8'h03, 1'b1, 24'hFFFC20, 1);

    // Aborted selections
    sel(); xbits(8'h06, 5); desel();
    stat_is(8'h00, "R6 partial opcode ignored");
    sel(); xbyte(8'h06, 1'b0); xbits(8'h00, 3); desel();
    stat_is(8'h00, "R6 extra bits cancel WREN");
    cmd1(8'h06);
    sel(); xbyte(8'h02, 1'b0); xbyte(8'h00, 1'b0); xbyte(8'h00, 1'b0); xbyte(8'h30, 1'b0); desel();
    stat_is(8'h02, "R6 program without data byte not run");
    expect_b(8'hFF, "R6 array untouched");
    stream(8'h03, 1'b1, 24'h000030, 1);
    cmd1(8'h04);

    // Status write pairing
    cmd_data(8'h01, 8'h3C);
    stat_is(8'h00, "R7 WRSR without EWSR");
    cmd1(8'h50);
    stat_is(8'h00, "R11 status during arm");
    cmd_data(8'h01, 8'h3C);
    stat_is(8'h00, "R7 WRSR not adjacent to EWSR");
    cmd1(8'h50);
    cmd_data(8'h01, 8'hFF);
    stat_is(8'hBC, "R7 WRSR stores bits 7 and 5..2");
    cmd1(8'h50);
    cmd_data(8'h01, 8'h00);
    stat_is(8'h00, "R7 WRSR clears stored bits");

    // Sequential programming
    cmd1(8'h06);
    cmd_addr(8'hAF, 24'h000040, 1'b1, 8'hA1);
    stat_is(8'h42, "R8 sequential flag bit6");
    cmd_data(8'hAF, 8'hA2);
    cmd_data(8'hAF, 8'hA3);
    cmd1(8'h04);
    stat_is(8'h00, "R8 WRDI ends sequential mode");
    expect_b(8'hA1, "R8 first byte"); expect_b(8'hA2, "R8 next address");
    expect_b(8'hA3, "R8 next address"); expect_b(8'hFF, "R8 end of run");
    stream(8'h03, 1'b1, 24'h000040, 4);

    // Identification
    expect_b(8'hBF, "R9 maker code"); expect_b(8'h48, "R9 device code"); expect_b(8'hBF, "R9 alternation");
    stream(8'h90, 1'b1, 24'h000000, 3);
    expect_b(8'h48, "R9 device first"); expect_b(8'hBF, "R9 alternation");
    stream(8'hAB, 1'b1, 24'h000001, 2);

    // Sector and block fill
    cmd1(8'h06); cmd_addr(8'h02, 24'h000100, 1'b1, 8'h33);
    cmd1(8'h06); cmd_addr(8'h02, 24'h0001FF, 1'b1, 8'h44);
    cmd1(8'h06); cmd_addr(8'h02, 24'h000200, 1'b1, 8'h55);
    expect_b(8'h44, "R5 program"); expect_b(8'h55, "R5 program");
    stream(8'h03, 1'b1, 24'h0001FF, 2);
    cmd1(8'h06);
    cmd_addr(8'h20, 24'h0001A0, 1'b0, 8'h00);
    cmd1(8'h06);
    wait_clk(400);
    stat_is(8'h00, "R10 WREN ignored while busy");
    expect_b(8'hFF, "R10 sector start"); expect_b(8'hFF, "R10 sector end"); expect_b(8'h55, "R10 next sector kept");
    stream(8'h03, 1'b1, 24'h0001FE, 1);
    stream(8'h03, 1'b1, 24'h0001FF, 2);
    expect_b(8'hFF, "R10 sector base");
    stream(8'h03, 1'b1, 24'h000100, 1);
    cmd1(8'h06);
    cmd_addr(8'h52, 24'h000250, 1'b0, 8'h00);
    wait_clk(700);
    expect_b(8'hFF, "R10 block fill"); expect_b(8'h12, "R10 outside block kept");
    stream(8'h03, 1'b1, 24'h000200, 1);
    stream(8'h03, 1'b1, 24'h000020, 1);

    wait_clk(20);
    chk(exp_q.size() == 0, "R3 all expected bytes seen", 8'(exp_q.size()), 8'h00);
    summary();
  end

endmodule